// File: doc/BRIEF.md
# Hard-Decision Bit-Flipping LDPC Decoder

This block corrects an 8-bit hard-decision word received over a noisy link. The code is defined by a fixed 4x8 parity-check matrix. After a start request the decoder copies the received bits into a working estimate. It then runs passes until the estimate satisfies every parity check or an iteration cap is reached. In each pass, every check tells each of its bits what that bit would have to be for the check to hold. A bit is set against its received value when most of those messages contradict that value.

A client drives the received word together with a one-cycle start while the decoder is idle. It then waits for the one-cycle done pulse. At that point the decoder presents the corrected word, a success flag and the number of passes used. Starts that arrive during a decode are dropped.

Top module: `bfdec_top`

## Requirements
- R1: A start seen while idle loads the working estimate and the remembered received word from `rx_i`, so `word_o` equals that `rx_i` one cycle after the start edge and `busy_o` is 1.
- R2: Check j sends each bit i that it covers the XOR of the working estimates of the other bits that check j covers, which is the value bit i would need for check j to be even.
- R3: A bit is set to the complement of its received value only when a strict majority of the messages from the checks covering it differ from that received value; otherwise, including ties, it takes its received value.
- R4: After each update the syndrome has one bit per check: the XOR of the covered estimate bits. When it is all zero, decoding ends with `ok_o`=1.
- R5: If the syndrome is still nonzero after MAX_ITER passes (default 8), decoding ends with `ok_o`=0 and `iters_o`=MAX_ITER. `iters_o` never exceeds MAX_ITER.
- R6: Each pass takes two cycles, one for messages and one for the update and syndrome. `done_o` is high for exactly one cycle, 2*`iters_o` cycles after the start edge, and `busy_o` is 0 in that cycle.
- R7: A received word with zero syndrome finishes after the first pass with `iters_o`=1, `ok_o`=1 and `word_o` unchanged.
- R8: A start arriving while `busy_o`=1 is ignored: the running decode finishes with the result and timing of the original word.
- R9: Reset at 1 forces idle state. `word_o`, `ok_o`, `done_o`, `iters_o` and `busy_o` read 0 during reset and hold there until a start.
- R10: The matrix rows, as masks over bit index 7..0, are check0=8'h47, check1=8'h99, check2=8'h6A, check3=8'hB4. Every bit is covered by exactly two checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle decode request, used only while idle |
| rx_i | input | 8 | Received hard-decision word, sampled with start_i |
| word_o | output | 8 | Working estimate; the corrected word when done_o is high |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| ok_o | output | 1 | 1 if the final syndrome is zero; valid with done_o |
| iters_o | output | $clog2(MAX_ITER+1) | Passes completed |
| busy_o | output | 1 | High while a decode is in progress |

## Verification
A wrong message or flip decision inside a pass changes the estimate on the update edge of that pass. It therefore shows up at `word_o` and in the syndrome-driven `ok_o` when the decoder completes, and the decoder can complete as early as two cycles after start. A fault in the pass counter or the stop condition moves the done pulse away from 2*`iters_o` cycles, or lets a nonzero-syndrome word end before the cap. The vectors include valid codewords, a single error that corrects in one pass, and an error on a bit pair that shares both checks. That pair oscillates until the cap, which exposes the iteration limit and the parity of the final estimate.

// File: rtl/bfdec_pkg.sv
package bfdec_pkg;

    localparam int N_BITS = 8;
    localparam int N_CHK  = 4;

    typedef logic [N_BITS-1:0] word_t;
    typedef logic [N_CHK-1:0]  chk_t;

    // Row masks of the parity-check matrix, bit 7..0.
    localparam word_t H_ROWS [N_CHK] = '{8'h47, 8'h99, 8'h6A, 8'hB4};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_UPD  = 2'd2
    } state_e;

    typedef struct packed {
        logic load;
        logic msg_en;
        logic upd_en;
    } ctrl_t;

    // Checks that cover bit idx.
    function automatic chk_t col_mask(input int idx);
        chk_t m;
        for (int j = 0; j < N_CHK; j++) begin
            m[j] = H_ROWS[j][idx];
        end
        return m;
    endfunction

    // One parity bit per check.
    function automatic chk_t syndrome(input word_t w);
        chk_t s;
        for (int j = 0; j < N_CHK; j++) begin
            s[j] = ^(w & H_ROWS[j]);
        end
        return s;
    endfunction

endpackage

// File: rtl/bfdec_chk_node.sv
module bfdec_chk_node
    import bfdec_pkg::*;
#(
    parameter int ROW = 0
) (
    input  word_t est_i,
    output word_t msg_o
);
    localparam word_t MASK = H_ROWS[ROW];

    logic par;

    always_comb begin
        par   = ^(est_i & MASK);
        // Removing bit i from the full parity leaves the parity of the others.
        msg_o = MASK & ({N_BITS{par}} ^ est_i);
    end
endmodule

// File: rtl/bfdec_bit_node.sv
module bfdec_bit_node
    import bfdec_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic rx_bit,
    input  chk_t msg_i,
    output logic est_o
);
    localparam chk_t CMASK = col_mask(IDX);
    localparam int   DEG   = $countones(CMASK);

    chk_t disagree;
    int   cnt;

    always_comb begin
        disagree = CMASK & (msg_i ^ {N_CHK{rx_bit}});
        cnt      = $countones(disagree);
        est_o    = (2 * cnt > DEG) ? ~rx_bit : rx_bit;
    end
endmodule

// File: rtl/bfdec_ctrl.sv
module bfdec_ctrl
    import bfdec_pkg::*;
#(
    parameter  int MAX_ITER = 8,
    localparam int ITW      = $clog2(MAX_ITER + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           syn_zero_i,
    output ctrl_t          ctrl_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           ok_o,
    output logic [ITW-1:0] iters_o
);
    localparam logic [ITW-1:0] LAST_IT = ITW'(MAX_ITER - 1);

    state_e         state;
    logic [ITW-1:0] iter;
    logic           finish;

    always_comb begin
        ctrl_o.load   = (state == ST_IDLE) && start_i;
        ctrl_o.msg_en = (state == ST_MSG);
        ctrl_o.upd_en = (state == ST_UPD);
        finish        = syn_zero_i || (iter == LAST_IT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            iter   <= '0;
            done_o <= 1'b0;
            ok_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state <= ST_MSG;
                        iter  <= '0;
                        ok_o  <= 1'b0;
                    end
                end
                ST_MSG: begin
                    state <= ST_UPD;
                end
                ST_UPD: begin
                    iter <= iter + 1'b1;
                    if (finish) begin
                        state  <= ST_IDLE;
                        done_o <= 1'b1;
                        ok_o   <= syn_zero_i;
                    end else begin
                        state <= ST_MSG;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (state != ST_IDLE);
    assign iters_o = iter;
endmodule

// File: rtl/bfdec_top.sv
module bfdec_top
    import bfdec_pkg::*;
#(
    parameter  int MAX_ITER = 8,
    localparam int ITW      = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [N_BITS-1:0] rx_i,
    output logic [N_BITS-1:0] word_o,
    output logic              done_o,
    output logic              ok_o,
    output logic [ITW-1:0]    iters_o,
    output logic              busy_o
);
    ctrl_t ctrl;
    word_t est_q;
    word_t rx_q;
    word_t est_next;
    word_t msg_d [N_CHK];
    word_t msg_q [N_CHK];
    chk_t  col   [N_BITS];
    logic  syn_zero;

    bfdec_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .syn_zero_i (syn_zero),
        .ctrl_o     (ctrl),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ok_o       (ok_o),
        .iters_o    (iters_o)
    );

    for (genvar j = 0; j < N_CHK; j++) begin : g_chk
        bfdec_chk_node #(.ROW(j)) u_chk (
            .est_i (est_q),
            .msg_o (msg_d[j])
        );
    end

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        for (genvar j = 0; j < N_CHK; j++) begin : g_col
            assign col[i][j] = msg_q[j][i];
        end
        bfdec_bit_node #(.IDX(i)) u_bit (
            .rx_bit (rx_q[i]),
            .msg_i  (col[i]),
            .est_o  (est_next[i])
        );
    end

    assign syn_zero = (syndrome(est_next) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            est_q <= '0;
            rx_q  <= '0;
            for (int j = 0; j < N_CHK; j++) msg_q[j] <= '0;
        end else begin
            if (ctrl.load) begin
                est_q <= rx_i;
                rx_q  <= rx_i;
            end
            if (ctrl.msg_en) begin
                for (int j = 0; j < N_CHK; j++) msg_q[j] <= msg_d[j];
            end
            if (ctrl.upd_en) begin
                est_q <= est_next;
            end
        end
    end

    assign word_o = est_q;
endmodule

// File: rtl/bfdec_checker.sv
module bfdec_checker
    import bfdec_pkg::*;
#(
    parameter  int MAX_ITER = 8,
    localparam int ITW      = $clog2(MAX_ITER + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [N_BITS-1:0] rx_i,
    input logic [N_BITS-1:0] word_o,
    input logic              done_o,
    input logic              ok_o,
    input logic [ITW-1:0]    iters_o,
    input logic              busy_o
);
    AST_LOAD_RX: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> (word_o == $past(rx_i) && busy_o)); // R1
    AST_OK_MEANS_EVEN: assert property (@(posedge clk) disable iff (rst) done_o |-> (ok_o == (syndrome(word_o) == '0))); // R4
    AST_FAIL_AT_CAP: assert property (@(posedge clk) disable iff (rst) (done_o && !ok_o) |-> (iters_o == ITW'(MAX_ITER))); // R5
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst) iters_o <= ITW'(MAX_ITER)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_o |-> (!busy_o && iters_o != '0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy_o && !start_i) |=> ($stable(word_o) && !busy_o)); // R9
endmodule

bind bfdec_top bfdec_checker #(.MAX_ITER(MAX_ITER)) u_bfdec_chk (.*);

// File: tb/sim_bfdec_top.sv
`timescale 1ns/1ps
module sim_bfdec_top;
    localparam int MAXIT = 8;
    localparam int ITW   = $clog2(MAXIT + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [7:0]     rx_i = '0;
    logic [7:0]     word_o;
    logic           done_o;
    logic           ok_o;
    logic [ITW-1:0] iters_o;
    logic           busy_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bfdec_top #(.MAX_ITER(MAXIT)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .rx_i(rx_i),
        .word_o(word_o), .done_o(done_o), .ok_o(ok_o),
        .iters_o(iters_o), .busy_o(busy_o)
    );

    // Matrix rows as stated in R10.
    localparam logic [7:0] HR [4] = '{8'h47, 8'h99, 8'h6A, 8'hB4};

    // {rx, expected word, expected ok, expected passes}
    localparam logic [20:0] VEC [6] = '{
        {8'h00, 8'h00, 1'b1, 4'd1},   // R7 zero codeword
        {8'h26, 8'h26, 1'b1, 4'd1},   // R7 nonzero codeword
        {8'hFF, 8'hFF, 1'b1, 4'd1},   // R7 all ones
        {8'h04, 8'h00, 1'b1, 4'd1},   // R3 single error corrected, ties kept
        {8'h02, 8'h02, 1'b0, 4'd8},   // R5 twin pair oscillates to cap
        {8'h40, 8'h40, 1'b0, 4'd8}    // R5 other twin
    };

    task automatic chk(input logic cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference from R2, R3, R4, R5.
    task automatic model(input logic [7:0] rx, output logic [7:0] w,
                         output logic ok, output int it);
        logic [7:0] nw;
        w  = rx;
        it = 0;
        ok = 1'b0;
        for (int p = 0; p < MAXIT; p++) begin
            it++;
            for (int i = 0; i < 8; i++) begin
                int dis = 0;
                int deg = 0;
                for (int j = 0; j < 4; j++) begin
                    if (HR[j][i]) begin
                        logic m;
                        m = (^(w & HR[j])) ^ w[i];
                        deg++;
                        if (m != rx[i]) dis++;
                    end
                end
                nw[i] = (2 * dis > deg) ? ~rx[i] : rx[i];
            end
            w = nw;
            begin
                logic z = 1'b1;
                for (int j = 0; j < 4; j++) if (^(w & HR[j])) z = 1'b0;
                if (z) begin
                    ok = 1'b1;
                    break;
                end
            end
        end
    endtask

    // Start a decode and wait for done; lat counts edges after the start edge.
    task automatic run(input logic [7:0] rx, output int lat, output logic tmo);
        @(negedge clk);
        start_i = 1'b1;
        rx_i    = rx;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        tmo = 1'b0;
        chk(word_o == rx && busy_o, "R1", "load", int'(word_o), int'(rx));
        while (!done_o) begin
            @(negedge clk);
            lat++;
            if (lat > 4 * MAXIT + 4) begin
                tmo = 1'b1;
                break;
            end
        end
        if (tmo) chk(1'b0, "R6", "timeout", lat, 0);
    endtask

    task automatic check_result(input logic [7:0] rx, input logic [7:0] ew,
                                input logic eok, input int eit, input int lat,
                                input string req);
        chk(word_o == ew, req, "word", int'(word_o), int'(ew));
        chk(ok_o == eok, "R4", "ok", int'(ok_o), int'(eok));
        chk(int'(iters_o) == eit, "R5", "iters", int'(iters_o), eit);
        chk(lat == 2 * eit, "R6", "latency", lat, 2 * eit);
        chk(!busy_o, "R6", "busy at done", int'(busy_o), 0);
        @(negedge clk);
        chk(!done_o, "R6", "pulse width", int'(done_o), 0);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic tmo;
        logic [7:0] mw;
        logic mok;
        int mit;

        repeat (3) @(negedge clk);
        chk(word_o == 8'h00 && !done_o && !ok_o && iters_o == '0 && !busy_o,
            "R9", "reset state", int'(word_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(word_o == 8'h00 && !busy_o, "R9", "idle hold", int'(word_o), 0);

        // Table walk: hand values cross-checked against the reference.
        foreach (VEC[k]) begin
            logic [7:0] rx, ew;
            logic eok;
            int eit;
            {rx, ew, eok} = VEC[k][20:4];
            eit = int'(VEC[k][3:0]);
            model(rx, mw, mok, mit);
            chk(mw == ew && mok == eok && mit == eit, "R2", "reference", int'(mw), int'(ew));
            run(rx, lat, tmo);
            check_result(rx, ew, eok, eit, lat, eit == 1 && rx == ew ? "R7" : "R3");
        end

        // Broader patterns against the reference (R2, R3, R4).
        for (int v = 1; v < 256; v += 23) begin
            model(8'(v), mw, mok, mit);
            run(8'(v), lat, tmo);
            check_result(8'(v), mw, mok, mit, lat, "R2");
        end

        // R8: a second start during a decode is dropped.
        @(negedge clk);
        start_i = 1'b1;
        rx_i    = 8'h02;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (3) begin
            @(negedge clk);
            lat++;
        end
        start_i = 1'b1;
        rx_i    = 8'h00;
        @(negedge clk);
        lat++;
        start_i = 1'b0;
        while (!done_o && lat < 4 * MAXIT + 4) begin
            @(negedge clk);
            lat++;
        end
        chk(word_o == 8'h02 && iters_o == ITW'(MAXIT) && !ok_o, "R8", "busy start ignored",
            int'(word_o), 8'h02);
        chk(lat == 2 * MAXIT, "R8", "latency kept", lat, 2 * MAXIT);

        // R9: reset in the middle of a decode.
        @(negedge clk);
        start_i = 1'b1;
        rx_i    = 8'h40;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(word_o == 8'h00 && !busy_o && !done_o && iters_o == '0 && !ok_o,
            "R9", "mid-decode reset", int'(word_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy_o && word_o == 8'h00, "R9", "stays idle", int'(busy_o), 0);

        // Recovery after reset (R10 matrix: 0x04 error on bit 2 corrects).
        run(8'h04, lat, tmo);
        check_result(8'h04, 8'h00, 1'b1, 1, lat, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule